// File: doc/BRIEF.md
# Transmit Event Timestamp Capture Queue

This block sits beside the transmit path of an Ethernet port and watches for the start of outgoing precision-time event messages. When such a message starts and its event type is enabled, the block copies the current time of day, made of 32-bit seconds and 32-bit nanoseconds, into a small first-in first-out store. The message's 16-bit sequence number and 4-bit message type go into the same entry. Software can then pair each timestamp with the packet it sent.

Software sees a pending flag whenever at least one entry is stored. It drains the store one entry at a time through a three-step handshake on a 2-bit read control word. Setting the start bit freezes the oldest entry onto the read outputs. Setting the end bit removes that entry. Writing zero re-arms the interface for the next entry.

A read-side state machine has three states:
- ARMED waits for the start bit. It goes to HOLD (transition LATCH) only when the store is not empty.
- HOLD keeps the frozen entry on the outputs. It goes to DONE (transition RELEASE) when the end bit is seen, and that pops one entry.
- DONE waits for an all-zero control word. It then returns to ARMED (transition REARM).

Top module: `ptp_txts_queue`

## Requirements
- R1: After reset, `ts_pending` and `ts_overflow` are 0, and `rd_time`, `rd_seq` and `rd_info` are all 0.
- R2: A message is captured only if `cfg_tx_slice_en` and `cfg_tx_cap_en` are both 1 in the cycle where `sop_strobe` is 1. Otherwise nothing is stored.
- R3: For a message of type t (0 to 3), the block looks at a 2-bit mode field in `cfg_evt_mode`. The field sits at bits [2t+1:2t] for a port-side message (`sop_from_cpu`=0) and at bits [8+2t+1:8+2t] for a CPU-side message (`sop_from_cpu`=1). The message is captured only when that field is non-zero.
- R4: Message types 4 to 15 are never captured, whatever the mode word holds.
- R5: `ts_pending` is 1 exactly when the store holds at least one entry. The flag updates one clock after the capture or pop that changes the store.
- R6: A captured entry holds the time of day seen at the clock edge where `sop_strobe` was sampled. On the read outputs:
  - `rd_time[15:0]` is nanoseconds [15:0] and `rd_time[31:16]` is nanoseconds [31:16].
  - `rd_time[47:32]` is seconds [15:0] and `rd_time[63:48]` is seconds [31:16].
  - `rd_info[15:12]` is the message type, `rd_info[11]` is 1 (transmit), and `rd_info[10:0]` is 0.
  - `rd_seq` is the sequence number.
- R7: With `rd_ctrl[0]`=1 in ARMED and a non-empty store, the oldest entry appears on the read outputs one clock later. The outputs then stay unchanged until the next LATCH.
- R8: `rd_ctrl[1]`=1 in HOLD pops exactly one entry. No further entry is presented or popped until `rd_ctrl` has been 0 for a cycle.
- R9: `rd_ctrl[0]`=1 while the store is empty changes neither the read outputs nor the store.
- R10: The store holds 4 entries. A capture that arrives while it is full, with no pop in the same cycle, is dropped and sets `ts_overflow`. `ts_overflow` then stays 1 until reset. A capture in the same cycle as a pop from a full store is kept.
- R11: Entries are read out in the order they were captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tx_slice_en | input | 1 | Transmit slice enable |
| cfg_tx_cap_en | input | 1 | Transmit capture enable |
| cfg_evt_mode | input | 16 | Per-event 2-bit mode fields; port side in [7:0], CPU side in [15:8] |
| tod_sec | input | 32 | Current time, seconds |
| tod_nsec | input | 32 | Current time, nanoseconds |
| sop_strobe | input | 1 | One-cycle start-of-packet pulse for an outgoing message |
| sop_from_cpu | input | 1 | 1 = message came from the CPU side, 0 = port side |
| sop_msg_type | input | 4 | Message type from the header |
| sop_seq_id | input | 16 | Sequence number from the header |
| rd_ctrl | input | 2 | Read control: bit 0 start, bit 1 end, zero re-arms |
| ts_pending | output | 1 | At least one entry is stored |
| ts_overflow | output | 1 | Sticky flag: a capture was dropped because the store was full |
| rd_time | output | 64 | Frozen timestamp, four 16-bit words, nanoseconds low word first |
| rd_seq | output | 16 | Frozen sequence number |
| rd_info | output | 16 | Frozen info word: type in [15:12], transmit flag in [11] |

## Verification
If the count or pointers go wrong, the next check of `ts_pending` against the bench's queue length shows it, one clock after the capture or pop that caused it. A wrong state in the read machine shows up as a frozen entry that is presented too early or popped twice. Either one gives wrong `rd_seq` or `rd_time` values in the cycle after the next start request. A wrong field select in the mode word or the type filter shows up as an entry that should not be there. It surfaces one clock later through the pending flag, or later through the order of read-out.

// File: rtl/ptpq_pkg.sv
package ptpq_pkg;
    localparam int EVT_TYPES   = 4;
    localparam int MODE_FLD_W  = 2;
    localparam int CPU_FLD_OFS = 8;

    typedef struct packed {
        logic [31:0] sec;
        logic [31:0] nsec;
        logic [15:0] seq;
        logic [3:0]  mtype;
    } tsq_entry_t;

    typedef enum logic [1:0] {
        RD_ARMED = 2'd0,
        RD_HOLD  = 2'd1,
        RD_DONE  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/ptpq_classify.sv
module ptpq_classify
    import ptpq_pkg::*;
#(
    parameter int MODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              slice_en,
    input  logic              cap_en,
    input  logic [MODE_W-1:0] mode,
    input  logic              from_cpu,
    input  logic [3:0]        mtype,
    output logic              capture
);
    logic [EVT_TYPES-1:0] hit;

    genvar e;
    generate
        for (e = 0; e < EVT_TYPES; e++) begin : g_evt
            logic [MODE_FLD_W-1:0] fld;
            assign fld    = from_cpu ? mode[CPU_FLD_OFS + MODE_FLD_W*e +: MODE_FLD_W]
                                     : mode[MODE_FLD_W*e +: MODE_FLD_W];
            assign hit[e] = (mtype == 4'(e)) && (fld != '0);
        end
    endgenerate

    assign capture = strobe && slice_en && cap_en && (|hit);

    // R4
    non_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mtype >= 4'(EVT_TYPES)) |-> !capture);
endmodule

// File: rtl/ptpq_store.sv
module ptpq_store
    import ptpq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  tsq_entry_t din,
    input  logic       pop,
    output tsq_entry_t head,
    output logic       not_empty,
    output logic       ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tsq_entry_t          mem [DEPTH];
    logic [AW-1:0]       wr_ptr, rd_ptr;
    logic [CW-1:0]       cnt;
    logic                full, accept;

    assign full      = (cnt == CW'(DEPTH));
    assign not_empty = (cnt != '0);
    assign accept    = push && (!full || pop);
    assign head      = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (pop)    rd_ptr <= bump(rd_ptr);
            if (accept) wr_ptr <= bump(wr_ptr);
            cnt <= cnt + CW'(accept) - CW'(pop);
            if (push && !accept) ovf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din;
    end

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R10
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> ovf);
    // R5
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);
endmodule

// File: rtl/ptpq_reader.sv
module ptpq_reader
    import ptpq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  rd_ctrl,
    input  logic        not_empty,
    input  tsq_entry_t  head,
    output logic        pop,
    output logic [63:0] rd_time,
    output logic [15:0] rd_seq,
    output logic [15:0] rd_info
);
    rd_state_e st, st_nx;
    logic      latch;

    assign latch = (st == RD_ARMED) && rd_ctrl[0] && not_empty;
    assign pop   = (st == RD_HOLD) && rd_ctrl[1];

    always_comb begin
        st_nx = st;
        unique case (st)
            RD_ARMED: if (latch)            st_nx = RD_HOLD;
            RD_HOLD:  if (rd_ctrl[1])       st_nx = RD_DONE;
            RD_DONE:  if (rd_ctrl == 2'b00) st_nx = RD_ARMED;
            default:                        st_nx = RD_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RD_ARMED;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_time <= '0;
            rd_seq  <= '0;
            rd_info <= '0;
        end else if (latch) begin
            rd_time <= {head.sec[31:16], head.sec[15:0], head.nsec[31:16], head.nsec[15:0]};
            rd_seq  <= head.seq;
            rd_info <= {head.mtype, 1'b1, 11'b0};
        end
    end

    // R8
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pop);
    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != RD_ARMED) |=> $stable(rd_time) && $stable(rd_seq));
    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RD_DONE && rd_ctrl != 2'b00) |=> (st == RD_DONE));
endmodule

// File: rtl/ptp_txts_queue.sv
module ptp_txts_queue
    import ptpq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int MODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_slice_en,
    input  logic              cfg_tx_cap_en,
    input  logic [MODE_W-1:0] cfg_evt_mode,
    input  logic [31:0]       tod_sec,
    input  logic [31:0]       tod_nsec,
    input  logic              sop_strobe,
    input  logic              sop_from_cpu,
    input  logic [3:0]        sop_msg_type,
    input  logic [15:0]       sop_seq_id,
    input  logic [1:0]        rd_ctrl,
    output logic              ts_pending,
    output logic              ts_overflow,
    output logic [63:0]       rd_time,
    output logic [15:0]       rd_seq,
    output logic [15:0]       rd_info
);
    logic       push, pop, not_empty;
    tsq_entry_t din, head;

    assign din = '{sec: tod_sec, nsec: tod_nsec, seq: sop_seq_id, mtype: sop_msg_type};

    ptpq_classify #(.MODE_W(MODE_W)) u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (sop_strobe),
        .slice_en (cfg_tx_slice_en),
        .cap_en   (cfg_tx_cap_en),
        .mode     (cfg_evt_mode),
        .from_cpu (sop_from_cpu),
        .mtype    (sop_msg_type),
        .capture  (push)
    );

    ptpq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .din       (din),
        .pop       (pop),
        .head      (head),
        .not_empty (not_empty),
        .ovf       (ts_overflow)
    );

    ptpq_reader u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_ctrl   (rd_ctrl),
        .not_empty (not_empty),
        .head      (head),
        .pop       (pop),
        .rd_time   (rd_time),
        .rd_seq    (rd_seq),
        .rd_info   (rd_info)
    );

    assign ts_pending = not_empty;

    // R2
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cfg_tx_slice_en && cfg_tx_cap_en && sop_strobe));
    // R5
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> ts_pending);
endmodule

// File: tb/ptp_txts_queue_tb.sv
module ptp_txts_queue_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slice_en = 1'b0, cap_en = 1'b0;
    logic [15:0] mode = '0;
    logic [31:0] tsec = '0, tnsec = '0;
    logic        sop = 1'b0, from_cpu = 1'b0;
    logic [3:0]  mtype = '0;
    logic [15:0] seq = '0;
    logic [1:0]  rdc = '0;
    logic        pend, ovf;
    logic [63:0] rtime;
    logic [15:0] rseq, rinfo;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_txts_queue dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_tx_slice_en(slice_en), .cfg_tx_cap_en(cap_en),
        .cfg_evt_mode(mode), .tod_sec(tsec), .tod_nsec(tnsec), .sop_strobe(sop),
        .sop_from_cpu(from_cpu), .sop_msg_type(mtype), .sop_seq_id(seq), .rd_ctrl(rdc),
        .ts_pending(pend), .ts_overflow(ovf), .rd_time(rtime), .rd_seq(rseq), .rd_info(rinfo)
    );

    // reference model
    logic [31:0] q_sec[$], q_nsec[$];
    logic [15:0] q_seq[$];
    logic [3:0]  q_typ[$];
    int          m_st = 0;
    logic        m_ovf = 1'b0;
    logic [63:0] m_time = '0;
    logic [15:0] m_seq = '0, m_info = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_sec.delete(); q_nsec.delete(); q_seq.delete(); q_typ.delete();
            m_st = 0; m_ovf = 1'b0; m_time = '0; m_seq = '0; m_info = '0;
        end else begin
            bit want, dopop;
            int base, fld, sz;
            sz = q_seq.size();
            base = from_cpu ? 8 : 0;
            fld = (mtype < 4) ? int'(mode[base + 2*mtype +: 2]) : 0;
            want = sop && slice_en && cap_en && (mtype < 4) && (fld != 0);
            dopop = (m_st == 1) && rdc[1];
            if (m_st == 0) begin
                if (rdc[0] && sz > 0) begin
                    m_time = {q_sec[0], q_nsec[0]};
                    m_seq  = q_seq[0];
                    m_info = {q_typ[0], 1'b1, 11'b0};
                    m_st = 1;
                end
            end else if (m_st == 1) begin
                if (rdc[1]) m_st = 2;
            end else if (rdc == 2'b00) m_st = 0;
            if (dopop) begin
                void'(q_sec.pop_front()); void'(q_nsec.pop_front());
                void'(q_seq.pop_front()); void'(q_typ.pop_front());
            end
            if (want) begin
                if (sz < QDEPTH || dopop) begin
                    q_sec.push_back(tsec); q_nsec.push_back(tnsec);
                    q_seq.push_back(seq);  q_typ.push_back(mtype);
                end else m_ovf = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison: R5 pending, R10 overflow, R6/R7 read outputs
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 pending", 64'(pend), 64'(q_seq.size() > 0));
            chk("R10 overflow", 64'(ovf), 64'(m_ovf));
            chk("R6 rd_time", rtime, m_time);
            chk("R7 rd_seq", 64'(rseq), 64'(m_seq));
            chk("R6 rd_info", 64'(rinfo), 64'(m_info));
        end
    end

    // time of day advances each cycle with a varied pattern
    always @(negedge clk) begin
        tsec  <= tsec + 32'h0001_0003;
        tnsec <= tnsec + 32'h0123_4567;
    end

    task automatic send(input logic [3:0] t, input logic [15:0] s, input logic cpu);
        @(negedge clk);
        sop = 1'b1; mtype = t; seq = s; from_cpu = cpu;
        @(negedge clk);
        sop = 1'b0;
    endtask

    task automatic read_one(output logic [15:0] got);
        @(negedge clk); rdc = 2'b01;
        @(negedge clk); got = rseq; rdc = 2'b10;
        @(negedge clk); rdc = 2'b00;
        @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] g;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pending", 64'(pend), 0);
        chk("R1 overflow", 64'(ovf), 0);
        chk("R1 rd_time", rtime, 0);
        chk("R1 rd_seq", 64'(rseq), 0);
        rst_n = 1'b1;
        mode = 16'h00FF;
        // R2 gating: one enable missing
        slice_en = 1'b1; cap_en = 1'b0;
        send(4'd0, 16'h0A01, 1'b0);
        slice_en = 1'b0; cap_en = 1'b1;
        send(4'd1, 16'h0A02, 1'b0);
        @(negedge clk); chk("R2 no capture", 64'(pend), 0);
        slice_en = 1'b1;
        // R4 non-event types
        send(4'd4, 16'h0B01, 1'b0);
        send(4'd15, 16'h0B02, 1'b0);
        mode = 16'hFFFF;
        send(4'd8, 16'h0B03, 1'b1);
        @(negedge clk); chk("R4 no capture", 64'(pend), 0);
        // R3 mode field select: only CPU-side Sync (bits 9:8) and port Pdelay_Resp (bits 7:6)
        mode = 16'h02C0;
        send(4'd0, 16'h0C01, 1'b0);
        send(4'd3, 16'h0C02, 1'b1);
        @(negedge clk); chk("R3 filtered", 64'(pend), 0);
        send(4'd0, 16'h0C03, 1'b1);
        send(4'd3, 16'h0C04, 1'b0);
        // R9 start with nonempty then check; first drain
        read_one(g); chk("R3 cpu sync captured / R11 order", 64'(g), 64'h0C03);
        read_one(g); chk("R3 port pdelay_resp captured", 64'(g), 64'h0C04);
        // R9 start on empty: outputs unchanged
        held = rtime;
        @(negedge clk); rdc = 2'b01;
        repeat (3) @(negedge clk);
        chk("R9 empty start keeps outputs", rtime, held);
        chk("R9 empty stays empty", 64'(pend), 0);
        rdc = 2'b00;
        // R8: end held long, start asserted again without zero -> no second pop
        mode = 16'h00FF;
        send(4'd1, 16'h0D01, 1'b0);
        send(4'd2, 16'h0D02, 1'b0);
        @(negedge clk); rdc = 2'b01;
        @(negedge clk); rdc = 2'b11;
        repeat (4) @(negedge clk);
        chk("R8 one pop per handshake", 64'(rseq), 64'h0D01);
        chk("R8 second entry still pending", 64'(pend), 1);
        rdc = 2'b00;
        read_one(g); chk("R8 next entry after rearm", 64'(g), 64'h0D02);
        // R10 fill and overflow, then R11 order
        for (int i = 0; i < 5; i++) send(4'(i % 4), 16'h0E00 + 16'(i), 1'b0);
        @(negedge clk); chk("R10 overflow set", 64'(ovf), 1);
        // R10 simultaneous pop on full keeps the capture
        @(negedge clk); rdc = 2'b01;
        @(negedge clk); rdc = 2'b10; sop = 1'b1; mtype = 4'd2; seq = 16'h0EFF; from_cpu = 1'b0;
        @(negedge clk); sop = 1'b0; rdc = 2'b00;
        @(negedge clk);
        for (int i = 1; i < 4; i++) begin
            read_one(g); chk("R11 fifo order", 64'(g), 64'h0E00 + 64'(i));
        end
        read_one(g); chk("R10 pop+push kept", 64'(g), 64'h0EFF);
        chk("R10 overflow sticky", 64'(ovf), 1);
        chk("R6 info type", 64'(rinfo), 64'h2800);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule